// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host side of a single read from an 8-bit successive-approximation converter reached over a four-wire serial link. A one-cycle request carries a channel number and a single-ended/differential flag. The controller then lowers the converter's select line and produces the serial clock by dividing the system clock. It sends a three-bit header and lets the settling slot pass. It collects the result twice, once MSB first and once with bits 1 to 7 repeated LSB first. When the transfer ends it raises the select line and reports the byte with a one-cycle valid strobe and an error flag.

The data line toward the converter comes with an output-enable. The host's data-out and the converter's data-out can therefore share one wire. The host stops driving when the header ends, which is before the converter starts to drive.

The sequencer has four states. ST_IDLE moves to ST_LEAD when a request arrives. ST_LEAD moves to ST_CLOCK after one half serial period. ST_CLOCK moves to ST_GAP on the falling serial edge that follows the last rising edge. ST_GAP returns to ST_IDLE after one full serial period.

Top module: `adc_read_ctrl`

## Requirements
- R1: After reset the select line is high, the serial clock is low, the data driver is disabled, and both `busy` and `valid` are low.
- R2: A request is taken only when `busy` is low. A request that arrives while busy changes neither the transfer in progress nor its result, and no transfer is queued.
- R3: The select line falls and rises only while the serial clock is low. It stays low across exactly 19 rising serial edges per transfer, and the serial clock stays low while the select line is high.
- R4: Every serial clock half period lasts `HALF_DIV` system clock cycles.
- R5: At rising serial edges 1, 2 and 3 the host data line carries 1 (start), then the single-ended flag, then the channel number. Each bit is stable at its edge.
- R6: The host data driver is switched off on the falling serial edge after rising edge 3. It stays off until the next transfer, so it is never enabled while the converter drives.
- R7: The bit sampled at rising edge 4 is the settling slot and does not enter the result. If it reads 1, `err` is set.
- R8: `result` is made of the bits sampled at rising edges 5 to 12, with the first of them as bit 7.
- R9: The bits sampled at rising edges 13 to 19 are result bits 1 to 7, in that order. If any of them differs from the same bit of the MSB-first byte, `err` is set.
- R10: `valid` is a one-cycle pulse in the same cycle that the select line rises. `result` and `err` keep their values until the next transfer ends.
- R11: Between two transfers the select line stays high for at least 2*`HALF_DIV` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle request for a read |
| req_chan | input | 1 | Channel number (sent as the third header bit) |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| busy | output | 1 | Transfer or inter-transfer gap in progress |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Host data toward converter |
| mosi_oe | output | 1 | Enable for the host data driver |
| miso | input | 1 | Converter data toward host |
| result | output | DATA_W | Converted byte |
| valid | output | 1 | One-cycle strobe, result ready |
| err | output | 1 | Settling-slot or copy mismatch fault |

## Verification
The bench includes a converter model that drives 00, 01, 80, 96 and FF for the four address combinations. A controller that miscounted the settling slot would shift every result by one bit, which these codes expose at both ends of the range. One run flips a single LSB-first bit and another raises the settling bit. A design that skipped the comparison, or took the settling slot as data, would return `err` low or a shifted byte. Monitors measure the half-period length, the select gap and any overlap of the two drivers, which catches late release of the shared wire. A request sent in mid-transfer must leave the result and the captured header untouched.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CLOCK,
        ST_GAP
    } rd_state_e;

    // header = start, single flag, channel
    localparam int HDR_RISES = 3;
    // rising edge that samples the settling slot
    localparam int SETTLE_RISE = HDR_RISES + 1;

endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
    import adc_rd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDXW   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic [IDXW-1:0]   idx,
    input  logic              bit_in,
    output logic [DATA_W-1:0] data_msb,
    output logic              mismatch,
    output logic              settle_hi
);
    localparam logic [IDXW-1:0] SETTLE_IDX = IDXW'(SETTLE_RISE);
    localparam logic [IDXW-1:0] MSB_FIRST  = IDXW'(SETTLE_RISE + 1);
    localparam logic [IDXW-1:0] MSB_LAST   = IDXW'(SETTLE_RISE + DATA_W);

    logic [DATA_W-1:1] lsb_copy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_msb  <= '0;
            settle_hi <= 1'b0;
        end else if (clear) begin
            data_msb  <= '0;
            settle_hi <= 1'b0;
        end else if (sample) begin
            if (idx == SETTLE_IDX) begin
                settle_hi <= bit_in;
            end
            if (idx >= MSB_FIRST && idx <= MSB_LAST) begin
                data_msb <= {data_msb[DATA_W-2:0], bit_in};
            end
        end
    end

    // one slot per repeated bit, filled in ascending order after the MSB-first byte
    for (genvar g = 1; g < DATA_W; g++) begin : g_lsb_slot
        localparam logic [IDXW-1:0] SLOT_IDX = IDXW'(SETTLE_RISE + DATA_W + g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lsb_copy[g] <= 1'b0;
            end else if (clear) begin
                lsb_copy[g] <= 1'b0;
            end else if (sample && idx == SLOT_IDX) begin
                lsb_copy[g] <= bit_in;
            end
        end
    end

    assign mismatch = (lsb_copy != data_msb[DATA_W-1:1]);
endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_chan,
    input  logic              req_single,
    output logic              busy,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    output logic              mosi_oe,
    input  logic              miso,
    output logic [DATA_W-1:0] result,
    output logic              valid,
    output logic              err
);
    localparam int LAST_RISE = SETTLE_RISE + DATA_W + (DATA_W - 1);
    localparam int IDXW      = $clog2(LAST_RISE + 1);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(LAST_RISE);
    localparam logic [IDXW-1:0] HDR1_IDX = IDXW'(1);
    localparam logic [IDXW-1:0] HDR2_IDX = IDXW'(2);
    localparam logic [IDXW-1:0] HDR_END  = IDXW'(HDR_RISES);

    rd_state_e state, state_nx;

    logic            tick;
    logic            sample;
    logic            clear;
    logic            gap_half;
    logic            chan_q;
    logic            single_q;
    logic [IDXW-1:0] rise_cnt;
    logic [IDXW-1:0] samp_idx;
    logic [DATA_W-1:0] cap_data;
    logic            cap_mism;
    logic            cap_settle;

    assign busy     = (state != ST_IDLE);
    assign clear    = (state == ST_IDLE) && req;
    assign sample   = (state == ST_CLOCK) && tick && !sclk;
    assign samp_idx = rise_cnt + IDXW'(1);

    adc_rd_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .tick  (tick)
    );

    adc_rd_capture #(.DATA_W(DATA_W), .IDXW(IDXW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .sample    (sample),
        .idx       (samp_idx),
        .bit_in    (miso),
        .data_msb  (cap_data),
        .mismatch  (cap_mism),
        .settle_hi (cap_settle)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req) state_nx = ST_LEAD;
            ST_LEAD:  if (tick) state_nx = ST_CLOCK;
            ST_CLOCK: if (tick && sclk && rise_cnt == LAST_IDX) state_nx = ST_GAP;
            ST_GAP:   if (tick && gap_half) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n     <= 1'b1;
            sclk     <= 1'b0;
            mosi     <= 1'b0;
            mosi_oe  <= 1'b0;
            rise_cnt <= '0;
            gap_half <= 1'b0;
            chan_q   <= 1'b0;
            single_q <= 1'b0;
            valid    <= 1'b0;
            err      <= 1'b0;
            result   <= '0;
        end else begin
            valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        cs_n     <= 1'b0;
                        mosi     <= 1'b1;
                        mosi_oe  <= 1'b1;
                        rise_cnt <= '0;
                        gap_half <= 1'b0;
                        chan_q   <= req_chan;
                        single_q <= req_single;
                    end
                end
                ST_LEAD: begin
                end
                ST_CLOCK: begin
                    if (tick && !sclk) begin
                        sclk     <= 1'b1;
                        rise_cnt <= samp_idx;
                    end else if (tick) begin
                        sclk <= 1'b0;
                        if (rise_cnt == HDR1_IDX) begin
                            mosi <= single_q;
                        end else if (rise_cnt == HDR2_IDX) begin
                            mosi <= chan_q;
                        end else if (rise_cnt == HDR_END) begin
                            mosi    <= 1'b0;
                            mosi_oe <= 1'b0;
                        end else if (rise_cnt == LAST_IDX) begin
                            cs_n   <= 1'b1;
                            valid  <= 1'b1;
                            result <= cap_data;
                            err    <= cap_mism || cap_settle;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) gap_half <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/adc_read_ctrl_chk.sv
module adc_read_ctrl_chk #(
    parameter int HALF_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic mosi_oe,
    input logic busy,
    input logic valid
);
    localparam int LIMIT = 2 * HALF_DIV;
    localparam int GW    = $clog2(LIMIT + 1) + 1;
    localparam logic [GW-1:0] LIM_V = GW'(LIMIT);

    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= LIM_V;
        end else if (!cs_n) begin
            gap_cnt <= '0;
        end else if (gap_cnt < LIM_V) begin
            gap_cnt <= gap_cnt + GW'(1);
        end
    end

    assert_cs_edge_sclk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n) || $fell(cs_n)) |-> !sclk);

    assert_sclk_quiet_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_busy_while_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    assert_no_drive_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !mosi_oe);

    assert_release_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mosi_oe) |-> $fell(sclk));

    assert_valid_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $rose(cs_n));

    assert_gap_length_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> gap_cnt >= LIM_V);
endmodule

bind adc_read_ctrl adc_read_ctrl_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .mosi_oe (mosi_oe),
    .busy    (busy),
    .valid   (valid)
);

// File: tb/tb_adc_read_ctrl.sv
`timescale 1ns/1ps
module tb_adc_read_ctrl;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_chan = 1'b0, req_single = 1'b0;
    logic busy, cs_n, sclk, mosi, mosi_oe, miso, valid, err;
    logic [7:0] result;

    always #2 clk = ~clk;

    adc_read_ctrl #(.DATA_W(8), .HALF_DIV(D)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_chan(req_chan),
        .req_single(req_single), .busy(busy), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso), .result(result),
        .valid(valid), .err(err)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // converter model: shared-wire pull-ups when nobody drives
    logic [7:0] m_code = 8'h00;
    bit   settle_inj = 1'b0;
    int   corrupt_at = 0;
    logic m_oe = 1'b0, m_do = 1'b0;
    int   m_rc = 0;
    bit   s_start, s_sgl, s_odd;
    logic di;

    assign di   = mosi_oe ? mosi : 1'b1;
    assign miso = m_oe ? m_do : 1'b1;

    always @(posedge sclk or negedge cs_n) begin
        if (!sclk) begin
            m_rc = 0;
        end else begin
            m_rc = m_rc + 1;
            if (m_rc == 1) s_start = di;
            if (m_rc == 2) s_sgl = di;
            if (m_rc == 3) s_odd = di;
        end
    end

    always @(negedge sclk or posedge cs_n) begin
        if (cs_n || m_rc >= 19) begin
            m_oe = 1'b0;
        end else if (m_rc == 3) begin
            m_oe = 1'b1;
            m_do = settle_inj;
        end else if (m_rc >= 4 && m_rc <= 11) begin
            m_do = m_code[11 - m_rc];
        end else if (m_rc >= 12) begin
            m_do = m_code[m_rc - 11] ^ (m_rc == corrupt_at);
        end
    end

    // monitors: half period, select gap, driver overlap
    int hp_len = 0, hp_bad = 0, gap_len = 0, gap_bad = 0, overlap = 0;
    bit hp_arm = 1'b0, gap_arm = 1'b0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mosi_oe && (m_oe || m_rc >= 4)) overlap++;
            if (cs_n) begin
                hp_arm = 1'b0;
                gap_len++;
            end else begin
                if (prev_cs && gap_arm && gap_len < 2 * D) gap_bad++;
                gap_arm = 1'b1;
                gap_len = 0;
                if (sclk != prev_sclk) begin
                    if (hp_arm && hp_len != D) hp_bad++;
                    hp_arm = 1'b1;
                    hp_len = 1;
                end else begin
                    hp_len++;
                end
            end
            prev_sclk = sclk;
            prev_cs   = cs_n;
        end
    end

    task automatic start_req(bit ch, bit sg);
        while (busy) @(negedge clk);
        req = 1'b1; req_chan = ch; req_single = sg;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!valid && t < 2000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic do_read(bit ch, bit sg, logic [7:0] code, bit exp_err, string tag);
        m_code = code;
        start_req(ch, sg);
        wait_done();
        chk({tag, " R10 valid seen"}, valid, 1);
        chk({tag, " R10 cs_n high with valid"}, cs_n, 1);
        chk({tag, " R8 result"}, result, code);
        chk({tag, " R7/R9 err"}, err, exp_err);
        chk({tag, " R5 start bit"}, s_start, 1);
        chk({tag, " R5 single flag"}, s_sgl, sg);
        chk({tag, " R5 channel bit"}, s_odd, ch);
        chk({tag, " R3 rising edges"}, m_rc, 19);
        @(negedge clk);
        chk({tag, " R10 valid one cycle"}, valid, 0);
        chk({tag, " R10 result held"}, result, code);
    endtask

    task automatic test_reset();
        chk("R1 cs_n", cs_n, 1);
        chk("R1 sclk", sclk, 0);
        chk("R1 mosi_oe", mosi_oe, 0);
        chk("R1 busy", busy, 0);
        chk("R1 valid", valid, 0);
    endtask

    task automatic test_addresses();
        do_read(1'b0, 1'b0, 8'h96, 1'b0, "diff ch0");
        do_read(1'b1, 1'b0, 8'h01, 1'b0, "diff ch1");
        do_read(1'b0, 1'b1, 8'hFF, 1'b0, "single ch0");
        do_read(1'b1, 1'b1, 8'h00, 1'b0, "single ch1");
        do_read(1'b1, 1'b1, 8'h80, 1'b0, "single ch1 msb");
    endtask

    task automatic test_copy_mismatch();
        corrupt_at = 14;
        do_read(1'b0, 1'b1, 8'h5A, 1'b1, "R9 flipped copy");
        corrupt_at = 0;
        do_read(1'b0, 1'b1, 8'h5A, 1'b0, "R9 clean after fault");
    endtask

    task automatic test_settle_high();
        settle_inj = 1'b1;
        do_read(1'b1, 1'b0, 8'hC3, 1'b1, "R7 settle high");
        settle_inj = 1'b0;
    endtask

    task automatic test_busy_ignore();
        m_code = 8'h3C;
        start_req(1'b0, 1'b1);
        repeat (60) @(negedge clk);
        chk("R2 busy mid transfer", busy, 1);
        req = 1'b1; req_chan = 1'b1; req_single = 1'b0;
        @(negedge clk);
        req = 1'b0;
        wait_done();
        chk("R2 result of first request", result, 8'h3C);
        chk("R2 header of first request", {s_sgl, s_odd}, 2'b10);
        repeat (6 * D) @(negedge clk);
        chk("R2 nothing queued cs_n", cs_n, 1);
        chk("R2 nothing queued busy", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_addresses();
        test_copy_mismatch();
        test_settle_high();
        test_busy_ignore();
        chk("R4 half period deviations", hp_bad, 0);
        chk("R11 short select gaps", gap_bad, 0);
        chk("R6 driver overlap", overlap, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule